// File: doc/BRIEF.md
# Interrupt raw/enable status controller

This block gathers a parameterised number of interrupt lines behind a small register bus. Each line has a latched raw status bit. A hardware event input sets it, and so does a software write to the raw status register, which lets software simulate an event. A raw bit goes back to zero only through a write-one-to-clear register. Enable bits follow the same scheme: one register sets them and another clears them. A read-only view returns raw status masked by the enables.

Each line produces a one-cycle pulse when its raw bit becomes set while the line is enabled. A level output is high whenever any enabled line has its raw status set.

The bus has no wait states. A write takes effect at the next clock edge, and read data is combinational from the current state.

Top module: `irq_status_ctrl`

## Requirements
- R1: Reading byte offset 0x00 returns raw status AND enable in the low LINES bits, with zero above them. Writes to 0x00 change no state.
- R2: A high `hw_event` bit sets the matching raw bit at the next edge, whether or not the line is enabled.
- R3: Writing to offset 0x04 sets every raw bit whose data bit is 1 and leaves bits written 0 unchanged. Reading 0x04 returns the raw bits.
- R4: Writing to offset 0x08 clears every raw bit whose data bit is 1 and leaves bits written 0 unchanged. Offset 0x08 reads as 0.
- R5: Writing 1s to offset 0x0C sets enable bits, and writing 1s to offset 0x10 clears them. Zero bits leave enables unchanged. Reading 0x0C returns the enables, and 0x10 reads as 0.
- R6: `line_pulse[i]` is high for exactly the one cycle after the edge where raw bit i goes from 0 to 1, and only if line i is enabled after that same edge. Enabling a line whose raw bit is already set gives no pulse.
- R7: While raw bit i stays set, further set events on line i give no pulse.
- R8: If a set (hardware or software) and a raw-clear write hit the same bit at one edge, the bit ends at 1. The set also produces a pulse if the line is enabled.
- R9: A hardware event and a software set on the same line at one edge give a single set and at most one pulse.
- R10: `irq_out` is high exactly when at least one line has both its raw and enable bits set.
- R11: After reset, all raw bits, enable bits, pulses and `irq_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_event | input | LINES | Per-line hardware set request, sampled each edge |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte offset of the register access |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| line_pulse | output | LINES | One-cycle per-line interrupt pulse |
| irq_out | output | 1 | Aggregated level interrupt |

## Verification
The assertions assume that `hw_event`, `reg_wr_en`, `reg_addr` and `reg_wdata` are stable around each rising edge. They also assume that only one register is accessed per cycle, and that `reg_addr` is one of the five word offsets whenever a write is strobed. The bench changes inputs only on the falling edge. Its random phase draws addresses only from the five defined offsets, and its directed phase drives the collision cases on purpose: set with clear, hardware with software, and enable with a pending raw bit.

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int LINES = 8,
  parameter int AW    = 5,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] hw_event,
  input  logic             reg_wr_en,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic [LINES-1:0] line_pulse,
  output logic             irq_out
);
  localparam logic [AW-1:0] OFS_MASKED = AW'(5'h00);
  localparam logic [AW-1:0] OFS_RAW    = AW'(5'h04);
  localparam logic [AW-1:0] OFS_RCLR   = AW'(5'h08);
  localparam logic [AW-1:0] OFS_ENSET  = AW'(5'h0C);
  localparam logic [AW-1:0] OFS_ENCLR  = AW'(5'h10);

  logic [LINES-1:0] raw_q, en_q, pulse_q;
  logic [LINES-1:0] wbits, sw_set, clr_vec, set_vec, en_nxt;

  assign wbits   = reg_wdata[LINES-1:0];
  assign sw_set  = (reg_wr_en && reg_addr == OFS_RAW)  ? wbits : '0;
  assign clr_vec = (reg_wr_en && reg_addr == OFS_RCLR) ? wbits : '0;
  assign set_vec = hw_event | sw_set;

  always_comb begin
    en_nxt = en_q;
    if (reg_wr_en && reg_addr == OFS_ENSET) en_nxt = en_q | wbits;
    if (reg_wr_en && reg_addr == OFS_ENCLR) en_nxt = en_q & ~wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= '0;
      en_q    <= '0;
      pulse_q <= '0;
    end else begin
      raw_q   <= set_vec | (raw_q & ~clr_vec);
      en_q    <= en_nxt;
      pulse_q <= set_vec & (~raw_q | clr_vec) & en_nxt;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_MASKED: reg_rdata[LINES-1:0] = raw_q & en_q;
      OFS_RAW:    reg_rdata[LINES-1:0] = raw_q;
      OFS_ENSET:  reg_rdata[LINES-1:0] = en_q;
      default:    reg_rdata = '0;
    endcase
  end

  assign line_pulse = pulse_q;
  assign irq_out    = |(raw_q & en_q);
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int LINES = 8,
  parameter int AW    = 5,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LINES-1:0] hw_event,
  input logic [AW-1:0]    reg_addr,
  input logic [DW-1:0]    reg_rdata,
  input logic [LINES-1:0] line_pulse,
  input logic             irq_out,
  input logic [LINES-1:0] raw_q,
  input logic [LINES-1:0] en_q
);
  a_r1_masked_view: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(0)) |-> (reg_rdata[LINES-1:0] == (raw_q & en_q)));

  a_r2_hw_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_event != '0) |=> ((raw_q & $past(hw_event)) == $past(hw_event)));

  a_r4_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(8)) |-> (reg_rdata == '0));

  a_r6_pulse_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pulse & ~(en_q & raw_q)) == '0);

  a_r10_pulse_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pulse != '0) |-> irq_out);
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.LINES(LINES), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_event(hw_event), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .line_pulse(line_pulse), .irq_out(irq_out),
  .raw_q(raw_q), .en_q(en_q)
);

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
  localparam int L = 8;
  logic clk = 0, rst_n = 0;
  logic [L-1:0] hw_event = '0;
  logic reg_wr_en = 0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [L-1:0] line_pulse;
  logic irq_out;

  int n_checks = 0, n_fail = 0;
  logic [L-1:0] m_raw = '0, m_en = '0, m_pulse = '0;

  always #2.5 clk = ~clk;

  irq_status_ctrl uut (.clk(clk), .rst_n(rst_n), .hw_event(hw_event), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .line_pulse(line_pulse), .irq_out(irq_out));

  task automatic check(string req, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (%s): actual %h expected %h", req, tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic [4:0] a);
    case (a)
      5'h00: return {24'h0, m_raw & m_en};  // R1
      5'h04: return {24'h0, m_raw};         // R3
      5'h0C: return {24'h0, m_en};          // R5
      default: return 32'h0;                // R4, R5 clear registers
    endcase
  endfunction

  function automatic string read_req(logic [4:0] a);
    case (a)
      5'h00: return "R1";
      5'h04: return "R3";
      5'h08: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic model_edge();
    logic [L-1:0] en_new;
    en_new = m_en;
    for (int i = 0; i < L; i++) begin
      if (reg_wr_en && reg_addr == 5'h0C && reg_wdata[i]) en_new[i] = 1'b1;
      if (reg_wr_en && reg_addr == 5'h10 && reg_wdata[i]) en_new[i] = 1'b0;
    end
    for (int i = 0; i < L; i++) begin
      bit setb, clrb;
      setb = hw_event[i] || (reg_wr_en && reg_addr == 5'h04 && reg_wdata[i]);
      clrb = reg_wr_en && reg_addr == 5'h08 && reg_wdata[i];
      m_pulse[i] = setb && (!m_raw[i] || clrb) && en_new[i];
      if (setb) m_raw[i] = 1'b1;
      else if (clrb) m_raw[i] = 1'b0;
    end
    m_en = en_new;
  endtask

  task automatic step(logic [L-1:0] hw, logic wr, logic [4:0] a, logic [31:0] wd, string tag);
    hw_event = hw; reg_wr_en = wr; reg_addr = a; reg_wdata = wd;
    #1;
    check(read_req(a), tag, reg_rdata, model_read(a));
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R6", tag, {24'h0, line_pulse}, {24'h0, m_pulse});
    check("R10", tag, {31'h0, irq_out}, {31'h0, |(m_raw & m_en)});
  endtask

  task automatic idle_read(logic [4:0] a, string tag);
    step('0, 1'b0, a, 32'h0, tag);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    check("R11", "reset pulse", {24'h0, line_pulse}, 32'h0);
    check("R11", "reset irq", {31'h0, irq_out}, 32'h0);
    idle_read(5'h04, "R11 raw after reset");
    idle_read(5'h0C, "R11 enable after reset");
    // R2 capture while disabled, no pulse
    step(8'h01, 1'b0, 5'h04, 32'h0, "R2 disabled capture");
    idle_read(5'h04, "R2 raw visible");
    // R6 enabling with pending raw gives no pulse, R10 irq rises
    step('0, 1'b1, 5'h0C, 32'h0000_0003, "R6 enable pending");
    idle_read(5'h00, "R1 masked view");
    // R1 write to masked register ignored
    step('0, 1'b1, 5'h00, 32'hFFFF_FFFF, "R1 write ignored");
    idle_read(5'h0C, "R1 enable untouched");
    idle_read(5'h04, "R1 raw untouched");
    // R4 zero write no effect, then clear
    step('0, 1'b1, 5'h08, 32'h0, "R4 zero clear");
    idle_read(5'h04, "R4 raw kept");
    step('0, 1'b1, 5'h08, 32'h0000_0001, "R4 clear line0");
    idle_read(5'h08, "R4 reads zero");
    // R6 pulse on enabled line, R7 no repeat pulse
    step(8'h02, 1'b0, 5'h04, 32'h0, "R6 enabled pulse");
    step(8'h02, 1'b0, 5'h04, 32'h0, "R7 repeat event");
    step('0, 1'b1, 5'h04, 32'h0000_0002, "R7 repeat sw set");
    // R8 set and clear together
    step(8'h02, 1'b1, 5'h08, 32'h0000_0002, "R8 set beats clear");
    idle_read(5'h04, "R8 raw stays");
    // R3 software set
    step('0, 1'b1, 5'h0C, 32'h0000_00F0, "R5 enable upper");
    step('0, 1'b1, 5'h04, 32'h0000_0010, "R3 sw set line4");
    // R9 hw and sw same line
    step(8'h20, 1'b1, 5'h04, 32'h0000_0020, "R9 hw and sw");
    idle_read(5'h04, "R9 raw");
    // R5 enable clear, zero write, read zero
    step('0, 1'b1, 5'h10, 32'h0, "R5 zero enable clear");
    step('0, 1'b1, 5'h10, 32'h0000_0030, "R5 enable clear");
    idle_read(5'h10, "R5 clear reads zero");
    idle_read(5'h0C, "R5 enables");
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [4:0] a;
      a = 5'(4 * ($urandom % 5));
      step(L'($urandom & $urandom & $urandom), 1'($urandom), a, $urandom, "random");
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule